// File: doc/BRIEF.md
# Binary Superlayer Track Linker

The block searches a binary map of segment hits for charged-particle tracks. The map holds one bit per cell on a grid of 10 radial superlayers by 32 azimuthal supercells. When a start strobe arrives, the block captures the whole map together with a per-cell override mask. A set bit in the mask makes a dead or weak cell count as hit. The block also captures a configuration word that picks the azimuthal window width for each layer-to-layer step.

A survivor mask begins at the innermost superlayer and moves outward one superlayer per clock. At each step, every surviving cell widens to a window of neighbouring supercells, either three or five wide, and the window wraps around in azimuth. The widened mask is then ANDed with the next superlayer's hits in the same-numbered supercells.

When the walk reaches the outermost superlayer, the block presents two 32-bit words: one for tracks that reached the middle superlayer and one for tracks that reached the outer superlayer. A one-cycle completion pulse marks the moment both words are updated. Both words then hold until the next search completes.

Top module: `track_linker`

## Requirements
- R1: The effective hit of cell (layer l, supercell c) is the OR of `seg_hits` and `dead_mask` at bit index l*32+c. Layer 0 is innermost and layer 9 is outermost.
- R2: The survivors of layer 0 are exactly its effective hits.
- R3: A cell (l+1, c) survives when it has an effective hit and a layer-l survivor lies within a given azimuthal distance of c. That distance is 1 when `wide_cfg[l]` is 0 and 2 when it is 1. Bit 9 of `wide_cfg` has no effect.
- R4: Supercell distance wraps modulo 32, so supercell 31 and supercell 0 are neighbours.
- R5: Bit c of `trk_middle` is the layer-4 survivor in supercell c. Bit c of `trk_outer` is the layer-9 survivor in supercell c.
- R6: `done` is high for exactly one cycle. It rises after the 9th rising edge following the edge that accepted `start`. Both outputs update at that same edge and hold until the next completion.
- R7: A `start` that arrives while a search is running is ignored. It produces no extra completion and does not alter the running search's result.
- R8: `seg_hits`, `dead_mask` and `wide_cfg` are sampled only at the accepting edge. Later changes to them do not affect the result of that search.
- R9: After reset, `trk_outer` and `trk_middle` are zero, `done` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when the block is idle |
| seg_hits | input | 320 | Segment-hit map, bit l*32+c |
| dead_mask | input | 320 | Per-cell override forcing a hit, same layout |
| wide_cfg | input | 10 | Bit l selects a 5-wide window for step l to l+1 |
| trk_outer | output | 32 | Tracks reaching the outermost superlayer |
| trk_middle | output | 32 | Tracks reaching the middle superlayer (layer 4) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The edge that accepts `start` is counted as edge 0. The single completion pulse is due just after edge 9, and both result words change on that same edge. For every search, the driver pushes onto a queue the expected pair of words, computed by an independent walk over the grid, together with the exact cycle number of edge 9. On the falling edge after each `done`, the monitor pops one item and compares the two words and the arrival cycle. Any `done` that arrives with an empty queue is a miscompare, and this is how ignored restarts and late input changes are caught.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LINK = 1'b1
    } link_state_t;

    localparam int NARROW_REACH = 1;
    localparam int WIDE_REACH   = 2;
endpackage

// File: rtl/tl_spread.sv
module tl_spread #(
    parameter int N_CELLS = 32,
    parameter int NARROW  = tl_pkg::NARROW_REACH,
    parameter int WIDE    = tl_pkg::WIDE_REACH
) (
    input  logic [N_CELLS-1:0] cand,
    input  logic               wide,
    output logic [N_CELLS-1:0] reach
);
    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        logic hit_any;
        always_comb begin
            hit_any = 1'b0;
            for (int d = -WIDE; d <= WIDE; d++) begin
                if ((d >= -NARROW && d <= NARROW) || wide) begin
                    if (cand[(c + d + N_CELLS) % N_CELLS]) begin
                        hit_any = 1'b1;
                    end
                end
            end
        end
        assign reach[c] = hit_any;
    end
endmodule

// File: rtl/tl_grid.sv
module tl_grid #(
    parameter int N_LAYERS = 10,
    parameter int N_CELLS  = 32,
    localparam int SW      = $clog2(N_LAYERS),
    localparam int BITS    = N_LAYERS * N_CELLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BITS-1:0]    hits,
    input  logic [BITS-1:0]    force_on,
    input  logic [SW-1:0]      row_sel,
    output logic [N_CELLS-1:0] row
);
    logic [N_LAYERS-1:0][N_CELLS-1:0] grid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q <= '0;
        end else if (load) begin
            grid_q <= hits | force_on;
        end
    end

    assign row = grid_q[row_sel];
endmodule

// File: rtl/tl_fsm.sv
module tl_fsm #(
    parameter int N_LAYERS = 10,
    parameter int MID      = 4,
    localparam int SW      = $clog2(N_LAYERS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          advance,
    output logic          cap_mid,
    output logic          finish,
    output logic [SW-1:0] step,
    output logic          done
);
    import tl_pkg::*;

    localparam logic [SW-1:0] LAST_STEP = SW'(N_LAYERS - 1);
    localparam logic [SW-1:0] MID_STEP  = SW'(MID);

    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step    <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
            if (load) begin
                step <= SW'(1);
            end else if (advance) begin
                step <= step + SW'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        advance = 1'b0;
        cap_mid = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_LINK;
                end
            end
            ST_LINK: begin
                advance = 1'b1;
                cap_mid = (step == MID_STEP);
                if (step == LAST_STEP) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/track_linker.sv
module track_linker #(
    parameter int N_LAYERS = 10,
    parameter int N_CELLS  = 32,
    parameter int MID      = 4,
    localparam int SW      = $clog2(N_LAYERS),
    localparam int BITS    = N_LAYERS * N_CELLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BITS-1:0]    seg_hits,
    input  logic [BITS-1:0]    dead_mask,
    input  logic [N_LAYERS-1:0] wide_cfg,
    output logic [N_CELLS-1:0] trk_outer,
    output logic [N_CELLS-1:0] trk_middle,
    output logic               done
);
    logic               load, advance, cap_mid, finish;
    logic [SW-1:0]      step;
    logic [SW-1:0]      prev_step;
    logic [N_CELLS-1:0] row, reach, survive;
    logic [N_CELLS-1:0] cand_q, mid_q;
    logic [N_LAYERS-1:0] wide_q;

    tl_fsm #(.N_LAYERS(N_LAYERS), .MID(MID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .advance(advance), .cap_mid(cap_mid),
        .finish(finish), .step(step), .done(done)
    );

    tl_grid #(.N_LAYERS(N_LAYERS), .N_CELLS(N_CELLS)) u_grid (
        .clk(clk), .rst_n(rst_n), .load(load),
        .hits(seg_hits), .force_on(dead_mask),
        .row_sel(step), .row(row)
    );

    assign prev_step = step - SW'(1);

    tl_spread #(.N_CELLS(N_CELLS)) u_spread (
        .cand(cand_q), .wide(wide_q[prev_step]), .reach(reach)
    );

    assign survive = reach & row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q     <= '0;
            mid_q      <= '0;
            wide_q     <= '0;
            trk_outer  <= '0;
            trk_middle <= '0;
        end else begin
            if (load) begin
                cand_q <= seg_hits[N_CELLS-1:0] | dead_mask[N_CELLS-1:0];
                wide_q <= wide_cfg;
            end else if (advance) begin
                cand_q <= survive;
            end
            if (cap_mid) begin
                mid_q <= survive;
            end
            if (finish) begin
                trk_outer  <= survive;
                trk_middle <= mid_q;
            end
        end
    end
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int N_LAYERS = 10,
    parameter int N_CELLS  = 32,
    localparam int CW      = $clog2(N_LAYERS) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic [N_CELLS-1:0] trk_outer,
    input logic [N_CELLS-1:0] trk_middle
);
    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy && start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(N_LAYERS - 2)) begin
                busy <= 1'b0;
            end
        end
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CW'(N_LAYERS - 2)) |=> done); // R6
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy && cnt == CW'(N_LAYERS - 2))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(trk_outer) && $stable(trk_middle))); // R6
endmodule

bind track_linker tl_checker #(.N_LAYERS(N_LAYERS), .N_CELLS(N_CELLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .trk_outer(trk_outer), .trk_middle(trk_middle)
);

// File: tb/track_linker_test.sv
module track_linker_test;
    localparam int L = 10;
    localparam int N = 32;
    localparam int B = L * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [B-1:0] seg_hits = '0;
    logic [B-1:0] dead_mask = '0;
    logic [L-1:0] wide_cfg = '0;
    logic [N-1:0] trk_outer, trk_middle;
    logic         done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [N-1:0] q_a[$];
    logic [N-1:0] q_b[$];
    int           q_t[$];
    string        q_tag[$];

    track_linker uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .seg_hits(seg_hits), .dead_mask(dead_mask), .wide_cfg(wide_cfg),
        .trk_outer(trk_outer), .trk_middle(trk_middle), .done(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2*N-1:0] model(input logic [B-1:0] h,
                                             input logic [B-1:0] m,
                                             input logic [L-1:0] w);
        logic [B-1:0] e;
        logic [N-1:0] s, n, mid;
        e = h | m;
        s = e[N-1:0];
        mid = '0;
        for (int l = 1; l < L; l++) begin
            n = '0;
            for (int c = 0; c < N; c++) begin
                for (int d = -2; d <= 2; d++) begin
                    if ((d >= -1 && d <= 1) || w[l-1]) begin
                        if (s[(c + d + N) % N]) n[c] = 1'b1;
                    end
                end
            end
            s = n & e[l*N +: N];
            if (l == 4) mid = s;
        end
        return {s, mid};
    endfunction

    function automatic logic [B-1:0] put(input logic [B-1:0] g, input int l, input int c);
        logic [B-1:0] r;
        r = g;
        r[l*N + ((c % N + N) % N)] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [B-1:0] h, input logic [B-1:0] m,
                          input logic [L-1:0] w, input string tag);
        logic [2*N-1:0] r;
        @(negedge clk);
        seg_hits = h; dead_mask = m; wide_cfg = w; start = 1'b1;
        r = model(h, m, w);
        @(negedge clk);
        start = 1'b0;
        q_a.push_back(r[2*N-1:N]);
        q_b.push_back(r[N-1:0]);
        q_t.push_back(cyc + L - 1);
        q_tag.push_back(tag);
    endtask

    task automatic wait_empty;
        while (q_a.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input logic [B-1:0] h, input logic [B-1:0] m,
                       input logic [L-1:0] w, input string tag);
        launch(h, m, w, tag);
        wait_empty();
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_a.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R7 unexpected done actual=1 expected=0");
            end else begin
                check({q_tag[0], " outer R5"}, trk_outer, q_a[0]);
                check({q_tag[0], " middle R5"}, trk_middle, q_b[0]);
                checks++;
                if (cyc != q_t[0]) begin
                    fails++;
                    $display("FAIL %s latency R6 actual=%0d expected=%0d", q_tag[0], cyc, q_t[0]);
                end
                void'(q_a.pop_front()); void'(q_b.pop_front());
                void'(q_t.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [B-1:0] g, g2;
        repeat (3) @(negedge clk);
        check("R9 reset outer", trk_outer, '0);
        check("R9 reset middle", trk_middle, '0);
        check("R9 reset done", {31'b0, done}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run('0, '0, '0, "R2 empty grid");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, 7);
        run(g, '0, '0, "R1 straight column");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, 3 + l);
        run(g, '0, '0, "R3 narrow diagonal");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, 2 * l);
        run(g, '0, '0, "R3 shift two narrow");
        run(g, '0, {L{1'b1}}, "R3 shift two wide");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, (l < 4) ? 12 : 14);
        run(g, '0, 10'b0000001000, "R3 wide at step three");
        run(g, '0, 10'b1000000100, "R3 wide elsewhere");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, (l % 2 == 0) ? 31 : 0);
        run(g, '0, '0, "R4 wrap high low");
        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, 30 + 2 * l);
        run(g, '0, {L{1'b1}}, "R4 wrap wide");

        g = '0;
        for (int l = 0; l < L; l++) if (l != 7) g = put(g, l, 10);
        run(g, '0, '0, "R5 gap at layer seven");
        run(g, put('0, 7, 10), '0, "R1 mask fills gap");
        run('0, {B{1'b1}}, '0, "R1 mask all");

        g = '0;
        for (int l = 0; l < L; l++) g = put(g, l, 20);
        launch(g, '0, '0, "R8 inputs changed after start");
        seg_hits = '0; wide_cfg = {L{1'b1}}; dead_mask = put('0, 9, 5);
        wait_empty();

        launch(g, '0, '0, "R7 restart while busy");
        repeat (3) @(negedge clk);
        seg_hits = {B{1'b1}}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_empty();
        repeat (15) @(negedge clk);

        for (int i = 0; i < 20; i++) begin
            g = '0;
            g2 = '0;
            for (int k = 0; k < B / 32; k++) begin
                g[k*32 +: 32] = $urandom() | $urandom();
                g2[k*32 +: 32] = $urandom() & $urandom() & $urandom();
            end
            run(g, g2, L'($urandom()), "R3 random grid");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule